// File: doc/BRIEF.md
# Parallel Configuration Port Loader

This block sits on the host side of a byte-wide slave configuration port of a single target device. It takes configuration bytes from a valid/ready stream and clocks them into the target. It drives an active-low select line, an active-low direction line (low means host-to-target) and a configuration clock, and it watches the target's busy flag. A `start_i` pulse opens a write session. The byte flagged as last closes the stream. The loader then keeps the target selected and the clock running until the target raises its end-of-startup indication, or until a programmable timeout expires.

When no byte is pending, loading pauses by parking the configuration clock low while the select line stays asserted. A separate `rd_start_i` pulse runs a readback of a given number of bytes. Before it, the loader releases the select line, turns the direction line around and re-selects the target. Afterwards it releases the select line and restores the write direction. The configuration clock is the system clock divided by an even ratio taken from `div_i`. The data bus output enable is the inverse of the direction line.

Top module: `cfg_port_loader`

## Requirements
- R1: After reset, cs_n_o=1, rdwr_n_o=0, cfg_clk_o=0, s_ready_o=0, done_o=0, err_o=0 and rd_valid_o=0.
- R2: rdwr_n_o changes only in a cycle in which cs_n_o=1 and cfg_clk_o=0. While cs_n_o=1 the configuration clock stays low.
- R3: A byte leaves on a rising cfg_clk_o edge only when cs_n_o=0, rdwr_n_o=0 and busy_i=0. When busy_i=1 at that edge, the same byte stays on data_o for the next edge. Bytes reach the target in stream order.
- R4: s_ready_o is high only during a write session with the holding register empty. It is low while a byte waits for the target.
- R5: While running, cfg_clk_o has a period of div_i system cycles (bit 0 of div_i ignored; 0 acts as 2) and a 50% duty cycle. With no byte pending during a write session, it parks low.
- R6: Once a write session starts, cs_n_o stays low until end of startup or timeout is recorded. It then rises only with cfg_clk_o low.
- R7: done_o sets in the cycle after eos_i is sampled high during the post-load phase. done_o and err_o clear when the next write session starts.
- R8: If eos_i stays low, err_o sets exactly timeout_i system cycles after the rising clock edge that moved the last byte, and done_o stays low. done_o and err_o are never both high.
- R9: rd_start_i with a nonzero rd_len_i reads exactly rd_len_i bytes. Each byte is data_i captured on a rising cfg_clk_o edge with cs_n_o=0, rdwr_n_o=1 and busy_i=0, and is given on rd_data_o with a one-cycle rd_valid_o pulse. The session ends with cs_n_o=1 and rdwr_n_o=0. rd_len_i=0 does nothing.
- R10: data_oe_o is the inverse of rdwr_n_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_i | input | DIV_W | Clock divide ratio (even) |
| timeout_i | input | TMO_W | End-of-startup timeout in system cycles |
| start_i | input | 1 | Start a write session (pulse) |
| rd_start_i | input | 1 | Start a readback (pulse) |
| rd_len_i | input | LEN_W | Bytes to read back |
| s_valid_i | input | 1 | Stream byte valid |
| s_ready_o | output | 1 | Stream byte accepted |
| s_data_i | input | DATA_W | Stream byte |
| s_last_i | input | 1 | Marks the final byte of the image |
| rd_data_o | output | DATA_W | Readback byte |
| rd_valid_o | output | 1 | Readback byte strobe |
| done_o | output | 1 | End of startup seen |
| err_o | output | 1 | End-of-startup timeout |
| cfg_clk_o | output | 1 | Configuration clock |
| cs_n_o | output | 1 | Target select, active low |
| rdwr_n_o | output | 1 | Direction: 0 write, 1 read |
| data_o | output | DATA_W | Data bus towards the target |
| data_oe_o | output | 1 | Data bus output enable |
| data_i | input | DATA_W | Data bus from the target |
| busy_i | input | 1 | Target busy flag |
| eos_i | input | 1 | Target end-of-startup indication |

## Verification
The bench uses the default widths: 8-bit data, an 8-bit divider field, a 16-bit timeout and an 8-bit read length. It switches div_i between 2, 4 and 6 from session to session. Ratio 2 is the tightest case, where the stream must refill the holding register within one system cycle to keep the clock period exact. Ratio 6 gives long low phases, in which paused loading and a pseudo-random busy flag can be seen to hold words in place. A timeout of 20 cycles makes the end-of-startup error reachable, and the exact cycle at which err_o sets is checked.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_W_TURN,
    ST_WRITE,
    ST_W_EOS,
    ST_W_END,
    ST_R_TURN,
    ST_READ,
    ST_R_END,
    ST_BACK
  } ld_state_e;

endpackage

// File: rtl/cfgl_clk_div.sv
module cfgl_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             cclk_o,
  output logic             rise_o
);

  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt_q;
  logic             cclk_q;
  logic             active;
  logic             tick;

  always_comb begin
    half = {1'b0, div_i[DIV_W-1:1]};
    if (half == '0) half = DIV_W'(1);
  end

  // a high phase always completes; a low phase only runs on demand
  assign active = run_i | cclk_q;
  assign tick   = active && (cnt_q >= half - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      cclk_q <= 1'b0;
    end else if (!active) begin
      cnt_q  <= '0;
    end else if (tick) begin
      cnt_q  <= '0;
      cclk_q <= ~cclk_q;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
    end
  end

  assign cclk_o = cclk_q;
  assign rise_o = tick & ~cclk_q;

endmodule

// File: rtl/cfgl_hold.sv
module cfgl_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              s_valid_i,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  input  logic              consume_i,
  output logic              full_o,
  output logic              last_o,
  output logic [DATA_W-1:0] data_o
);

  logic              full_q;
  logic              last_q;
  logic [DATA_W-1:0] data_q;
  logic              accept;

  assign s_ready_o = en_i & ~full_q;
  assign accept    = s_valid_i & s_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      last_q <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      last_q <= s_last_i;
      data_q <= s_data_i;
    end else if (consume_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign last_o = last_q;
  assign data_o = data_q;

endmodule

// File: rtl/cfgl_rd_cap.sv
module cfgl_rd_cap #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o
);

  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= cap_i;
      if (cap_i) data_q <= data_i;
    end
  end

  assign rd_data_o  = data_q;
  assign rd_valid_o = valid_q;

endmodule

// File: rtl/cfgl_ctrl.sv
module cfgl_ctrl
  import cfgl_pkg::*;
#(
  parameter int TMO_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rd_start_i,
  input  logic [LEN_W-1:0] rd_len_i,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic             rise_i,
  input  logic             cclk_i,
  input  logic             hold_full_i,
  input  logic             hold_last_i,
  input  logic             busy_i,
  input  logic             eos_i,
  output logic             cs_n_o,
  output logic             rdwr_n_o,
  output logic             run_o,
  output logic             wr_en_o,
  output logic             consume_o,
  output logic             cap_o,
  output logic             done_o,
  output logic             err_o
);

  ld_state_e        st_q;
  logic             cs_n_q;
  logic             rdwr_n_q;
  logic             done_q;
  logic             err_q;
  logic [TMO_W-1:0] tmo_q;
  logic [TMO_W-1:0] tmo_lim;
  logic [LEN_W-1:0] left_q;
  logic             selected;

  assign tmo_lim  = (timeout_i == '0) ? '0 : timeout_i - TMO_W'(1);
  // busy is only meaningful while the target is selected
  assign selected = ~cs_n_q;

  assign consume_o = (st_q == ST_WRITE) && selected && !rdwr_n_q &&
                     !busy_i && rise_i && hold_full_i;
  assign cap_o     = (st_q == ST_READ) && selected && rdwr_n_q &&
                     !busy_i && rise_i;
  assign run_o     = ((st_q == ST_WRITE) && hold_full_i) ||
                     (st_q == ST_W_EOS) || (st_q == ST_READ);
  assign wr_en_o   = (st_q == ST_WRITE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cs_n_q   <= 1'b1;
      rdwr_n_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      tmo_q    <= '0;
      left_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q     <= ST_W_TURN;
            rdwr_n_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
          end else if (rd_start_i && (rd_len_i != '0)) begin
            st_q     <= ST_R_TURN;
            rdwr_n_q <= 1'b1;
            left_q   <= rd_len_i;
          end
        end
        ST_W_TURN: begin
          cs_n_q <= 1'b0;
          st_q   <= ST_WRITE;
        end
        ST_WRITE: begin
          if (consume_o && hold_last_i) begin
            st_q  <= ST_W_EOS;
            tmo_q <= '0;
          end
        end
        ST_W_EOS: begin
          if (eos_i) begin
            done_q <= 1'b1;
            st_q   <= ST_W_END;
          end else if (tmo_q >= tmo_lim) begin
            err_q  <= 1'b1;
            st_q   <= ST_W_END;
          end else begin
            tmo_q  <= tmo_q + TMO_W'(1);
          end
        end
        ST_W_END: begin
          if (!cclk_i) begin
            cs_n_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_R_TURN: begin
          cs_n_q <= 1'b0;
          st_q   <= ST_READ;
        end
        ST_READ: begin
          if (cap_o) begin
            left_q <= left_q - LEN_W'(1);
            if (left_q == LEN_W'(1)) st_q <= ST_R_END;
          end
        end
        ST_R_END: begin
          if (!cclk_i) begin
            cs_n_q <= 1'b1;
            st_q   <= ST_BACK;
          end
        end
        ST_BACK: begin
          rdwr_n_q <= 1'b0;
          st_q     <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n_o   = cs_n_q;
  assign rdwr_n_o = rdwr_n_q;
  assign done_o   = done_q;
  assign err_o    = err_q;

endmodule

// File: rtl/cfg_port_loader.sv
module cfg_port_loader #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8,
  parameter int TMO_W  = 16,
  parameter int LEN_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [TMO_W-1:0]  timeout_i,
  input  logic              start_i,
  input  logic              rd_start_i,
  input  logic [LEN_W-1:0]  rd_len_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_last_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cfg_clk_o,
  output logic              cs_n_o,
  output logic              rdwr_n_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] data_i,
  input  logic              busy_i,
  input  logic              eos_i
);

  logic cclk;
  logic rise;
  logic run;
  logic wr_en;
  logic consume;
  logic cap;
  logic hold_full;
  logic hold_last;

  cfgl_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_i),
    .cclk_o (cclk),
    .rise_o (rise)
  );

  cfgl_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (wr_en),
    .s_valid_i (s_valid_i),
    .s_data_i  (s_data_i),
    .s_last_i  (s_last_i),
    .s_ready_o (s_ready_o),
    .consume_i (consume),
    .full_o    (hold_full),
    .last_o    (hold_last),
    .data_o    (data_o)
  );

  cfgl_ctrl #(.TMO_W(TMO_W), .LEN_W(LEN_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .rd_start_i  (rd_start_i),
    .rd_len_i    (rd_len_i),
    .timeout_i   (timeout_i),
    .rise_i      (rise),
    .cclk_i      (cclk),
    .hold_full_i (hold_full),
    .hold_last_i (hold_last),
    .busy_i      (busy_i),
    .eos_i       (eos_i),
    .cs_n_o      (cs_n_o),
    .rdwr_n_o    (rdwr_n_o),
    .run_o       (run),
    .wr_en_o     (wr_en),
    .consume_o   (consume),
    .cap_o       (cap),
    .done_o      (done_o),
    .err_o       (err_o)
  );

  cfgl_rd_cap #(.DATA_W(DATA_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .data_i     (data_i),
    .rd_data_o  (rd_data_o),
    .rd_valid_o (rd_valid_o)
  );

  assign cfg_clk_o = cclk;
  assign data_oe_o = ~rdwr_n_o;

endmodule

// File: rtl/cfg_port_loader_chk.sv
module cfg_port_loader_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_n_o,
  input logic              rdwr_n_o,
  input logic              cfg_clk_o,
  input logic              s_valid_i,
  input logic              s_ready_o,
  input logic [DATA_W-1:0] data_o,
  input logic              done_o,
  input logic              err_o,
  input logic              rd_valid_o
);

  p_dir_desel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdwr_n_o != $past(rdwr_n_o)) |-> (cs_n_o && !cfg_clk_o));

  p_clk_low_desel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !cfg_clk_o);

  p_data_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(s_valid_i && s_ready_o) |-> $stable(data_o));

  p_ready_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_ready_o |-> (!cs_n_o && !rdwr_n_o));

  p_cs_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(cs_n_o) && !rdwr_n_o) |-> (done_o || err_o));

  p_done_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  p_rd_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> $past(!cs_n_o && rdwr_n_o));

endmodule

bind cfg_port_loader cfg_port_loader_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_cfg_port_loader.sv
module tb_cfg_port_loader;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;
  localparam int TMO_W  = 16;
  localparam int LEN_W  = 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [DIV_W-1:0]  div_i = 8'd2;
  logic [TMO_W-1:0]  timeout_i = 16'd500;
  logic start_i = 1'b0, rd_start_i = 1'b0;
  logic [LEN_W-1:0]  rd_len_i = '0;
  logic s_valid_i = 1'b0, s_last_i = 1'b0;
  logic [DATA_W-1:0] s_data_i = '0;
  logic s_ready_o, rd_valid_o, done_o, err_o, cfg_clk_o, cs_n_o, rdwr_n_o, data_oe_o;
  logic [DATA_W-1:0] rd_data_o, data_o;
  logic [DATA_W-1:0] data_i = 8'hA0;
  logic busy_i, eos_i;

  always #4 clk_i = ~clk_i;

  cfg_port_loader dut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // busy source
  logic busy_mode = 1'b0, busy_force = 1'b0, busy_pat = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  always @(negedge cfg_clk_o) begin
    lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    busy_pat <= lfsr[0];
  end
  assign busy_i = busy_mode ? busy_pat : busy_force;

  // target model and scoreboard queues
  logic [DATA_W-1:0] wr_exp[$];
  logic [DATA_W-1:0] rd_exp[$];
  int wr_rcv = 0, wr_total = 0, post_cnt = 0, stall_seen = 0, rd_got = 0;
  logic eos_en = 1'b1;
  time t_last = 0;
  logic got_last;
  assign got_last = (wr_rcv == wr_total) && !cs_n_o && !rdwr_n_o;
  assign eos_i    = eos_en && got_last && (post_cnt >= 3);

  always @(posedge cfg_clk_o) begin
    #1;
    if (!cs_n_o && !rdwr_n_o) begin
      if (got_last) post_cnt++; else post_cnt = 0;
      if (wr_exp.size() > 0) begin
        if (busy_i) begin
          stall_seen++;
          chk(data_o == wr_exp[0], "R3 held word", data_o, wr_exp[0]);
        end else begin
          logic [DATA_W-1:0] e;
          e = wr_exp.pop_front();
          chk(data_o == e, "R3 write order", data_o, e);
          wr_rcv++;
          t_last = $time;
        end
      end
    end else if (!cs_n_o && rdwr_n_o && !busy_i) begin
      rd_exp.push_back(data_i);
      data_i = data_i + 8'd7;
    end
  end

  // readback monitor
  always @(negedge clk_i) begin
    if (rd_valid_o) begin
      rd_got++;
      if (rd_exp.size() == 0) chk(1'b0, "R9 unexpected byte", rd_data_o, 0);
      else begin
        logic [DATA_W-1:0] e;
        e = rd_exp.pop_front();
        chk(rd_data_o == e, "R9 read byte", rd_data_o, e);
      end
    end
  end

  // direction changes
  always @(rdwr_n_o) begin
    #1;
    if (rst_ni) begin
      chk(cs_n_o && !cfg_clk_o, "R2 turn while deselected", {cs_n_o, cfg_clk_o}, 2);
      chk(data_oe_o == !rdwr_n_o, "R10 oe follows direction", data_oe_o, !rdwr_n_o);
    end
  end

  task automatic send(input logic [DATA_W-1:0] d, input bit last);
    s_data_i  = d;
    s_last_i  = last;
    s_valid_i = 1'b1;
    wr_exp.push_back(d);
    while (!s_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    s_valid_i = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
  endtask

  task automatic wait_end();
    int n = 0;
    while (!(done_o || err_o) && n < 5000) begin
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    time t1, t2, t_err;
    int base;
    bit low_seen;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk(cs_n_o == 1 && rdwr_n_o == 0 && cfg_clk_o == 0, "R1 port idle",
        {cs_n_o, rdwr_n_o, cfg_clk_o}, 4);
    chk(!s_ready_o && !done_o && !err_o && !rd_valid_o, "R1 flags clear",
        {s_ready_o, done_o, err_o, rd_valid_o}, 0);

    // continuous load, ratio 2
    div_i = 8'd2; eos_en = 1'b1; wr_total += 8;
    pulse_start();
    fork
      for (int i = 0; i < 8; i++) send(8'h10 + 8'(i), i == 7);
      begin
        @(posedge cfg_clk_o); @(posedge cfg_clk_o); t1 = $time;
        @(posedge cfg_clk_o); t2 = $time;
      end
    join
    chk((t2 - t1) == 16, "R5 period ratio 2", t2 - t1, 16);
    wait_end();
    chk(done_o == 1, "R7 done after eos", done_o, 1);
    chk(err_o == 0, "R8 no error", err_o, 0);
    chk(wr_rcv == 8, "R3 words delivered", wr_rcv, 8);
    repeat (10) @(negedge clk_i);
    chk(cs_n_o == 1, "R6 released after eos", cs_n_o, 1);

    // timeout
    div_i = 8'd4; timeout_i = 16'd20; eos_en = 1'b0; wr_total += 2;
    pulse_start();
    chk(done_o == 0, "R7 done cleared by start", done_o, 0);
    send(8'h55, 0); send(8'hAA, 1);
    wait_end();
    t_err = $time;
    chk(err_o == 1 && done_o == 0, "R8 timeout error", {done_o, err_o}, 1);
    chk((t_err - t_last) == 20 * 8 + 3, "R8 timeout cycle", t_err - t_last, 20 * 8 + 3);
    repeat (10) @(negedge clk_i);
    chk(cs_n_o == 1, "R6 released after timeout", cs_n_o, 1);

    // paused load, ratio 6, random busy
    div_i = 8'd6; timeout_i = 16'd2000; eos_en = 1'b1; busy_mode = 1'b1;
    base = wr_rcv; wr_total += 6;
    pulse_start();
    chk(err_o == 0, "R7 err cleared by start", err_o, 0);
    for (int i = 0; i < 3; i++) send(8'h70 + 8'(i), 0);
    repeat (200) @(negedge clk_i);
    chk(cfg_clk_o == 0, "R5 clock parked", cfg_clk_o, 0);
    chk(wr_rcv == base + 3, "R3 paused words", wr_rcv, base + 3);
    chk(cs_n_o == 0, "R6 held through pause", cs_n_o, 0);
    chk(s_ready_o == 1, "R4 ready when empty", s_ready_o, 1);
    repeat (12) @(negedge clk_i);
    chk(cfg_clk_o == 0, "R5 clock stays parked", cfg_clk_o, 0);
    for (int i = 3; i < 6; i++) send(8'h70 + 8'(i), i == 5);
    wait_end();
    chk(done_o == 1 && wr_rcv == base + 6, "R7 done paused load", wr_rcv, base + 6);
    repeat (20) @(negedge clk_i);

    // busy stall
    busy_mode = 1'b0; busy_force = 1'b1; div_i = 8'd2;
    base = wr_rcv; stall_seen = 0; wr_total += 2;
    pulse_start();
    send(8'hC3, 0);
    repeat (30) @(negedge clk_i);
    chk(s_ready_o == 0, "R4 ready low while held", s_ready_o, 0);
    chk(wr_rcv == base, "R3 no transfer while busy", wr_rcv, base);
    chk(stall_seen > 0, "R3 word re-presented", stall_seen, 1);
    @(negedge cfg_clk_o); busy_force = 1'b0;
    @(negedge clk_i);
    send(8'h3C, 1);
    wait_end();
    chk(done_o == 1 && wr_rcv == base + 2, "R3 stall then deliver", wr_rcv, base + 2);
    repeat (10) @(negedge clk_i);

    // readback
    div_i = 8'd4; busy_mode = 1'b1; rd_got = 0; rd_len_i = 8'd5;
    @(negedge clk_i); rd_start_i = 1'b1;
    @(negedge clk_i); rd_start_i = 1'b0;
    while (cs_n_o) @(negedge clk_i);
    chk(rdwr_n_o == 1 && data_oe_o == 0, "R10 read drives off", {rdwr_n_o, data_oe_o}, 2);
    for (int n = 0; n < 3000 && rd_got < 5; n++) @(negedge clk_i);
    repeat (30) @(negedge clk_i);
    chk(rd_got == 5, "R9 read count", rd_got, 5);
    chk(cs_n_o == 1 && rdwr_n_o == 0, "R9 read session closed", {cs_n_o, rdwr_n_o}, 2);
    chk(data_oe_o == 1, "R10 write drive restored", data_oe_o, 1);

    // zero-length readback
    rd_len_i = 8'd0; low_seen = 0;
    @(negedge clk_i); rd_start_i = 1'b1;
    @(negedge clk_i); rd_start_i = 1'b0;
    for (int n = 0; n < 20; n++) begin
      @(negedge clk_i);
      if (!cs_n_o || rdwr_n_o) low_seen = 1;
    end
    chk(low_seen == 0 && rd_got == 5, "R9 zero length ignored", low_seen, 0);

    finished = 1;
    summary();
    $finish;
  end

endmodule